// File: doc/BRIEF.md
# Hall Position Sampling Noise Filter

This block cleans up the three Hall-sensor position inputs of a brushless motor before the rest of the chip uses them. The raw inputs first cross into the system clock domain through a two-flop synchronizer. They are then sampled on a slower sampling tick, which is the system clock divided by 4, 8, 32 or 128. A new 3-bit position is taken only once the same code has been seen on a programmed number of back-to-back samples. A short spike therefore never reaches the latched position.

Sampling can run all the time, or only while the PWM output is on, or only while a low-side phase conducts. Noise after a PWM switch-on edge can be masked by a blanking window, counted in sampling ticks. While detection is disabled, the held position is frozen. Each time the held position moves to a new code, a one-cycle strobe marks the change, so speed-capture or commutation logic can react to it.

Top module: `hall_pos_filter`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises, pos_out is 3'b000 and pos_chg is 0.
- R2: clk_sel selects the sampling tick period in system clocks: 2'b00 gives 4, 2'b01 gives 8, 2'b10 gives 32 and 2'b11 gives 128. The Hall inputs pass through two synchronizer flops before they are sampled.
- R3: match_cnt (4 bits) sets how many consecutive identical samples are needed before a code is accepted, from 1 to 15. The values 0 and 1 both require a single sample.
- R4: A sample that differs from the current candidate restarts the consecutive count. A pulse shorter than the required run leaves pos_out unchanged.
- R5: samp_mode selects the sampling gate: 2'b00 samples only while pwm_on is 1, 2'b01 samples on every tick, 2'b10 samples only while lowside_on is 1, and 2'b11 takes no samples.
- R6: A rising edge of pwm_on suppresses sampling for blank_dly (0 to 127) sampling ticks. A value of 0 adds no blanking.
- R7: While det_en is 0, pos_out keeps its value whatever the Hall inputs do, and pos_chg stays 0.
- R8: pos_chg is 1 for exactly one system clock, in the same cycle that pos_out takes a new value that differs from the old one, and is 0 at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hall_in | input | 3 | Raw asynchronous Hall sensor inputs |
| pwm_on | input | 1 | PWM output currently on |
| lowside_on | input | 1 | A low-side phase currently conducts |
| det_en | input | 1 | Position detection enable |
| clk_sel | input | 2 | Sampling tick divider select |
| samp_mode | input | 2 | Sampling gate mode |
| match_cnt | input | 4 | Required consecutive identical samples |
| blank_dly | input | 7 | Blanking length after PWM switch-on, in sampling ticks |
| pos_out | output | 3 | Accepted, latched Hall position |
| pos_chg | output | 1 | One-cycle strobe on a position change |

## Verification
On every cycle, the assertions check the following. The strobe never lasts two cycles. It matches a real change of pos_out, and pos_out never moves without it. The position also stays frozen whenever detection is off, the reserved mode is chosen, or PWM-gated mode sees PWM off. Other behaviour depends on timing over long windows and only the bench scenarios can show it: the divider ratios, the run length for each count setting, glitch rejection, and the blanking window after a PWM switch-on. The bench sets the hold times so that the result is the same at every phase of the sampling tick.

// File: rtl/hpf_pkg.sv
package hpf_pkg;

   typedef enum logic [1:0] {
      SMP_PWM  = 2'b00,
      SMP_FREE = 2'b01,
      SMP_LOW  = 2'b10,
      SMP_NONE = 2'b11
   } smp_mode_e;

   localparam int unsigned MAX_DIV   = 128;
   localparam int unsigned PRE_W     = $clog2(MAX_DIV);

   // terminal count of the prescaler for each select code
   function automatic logic [PRE_W-1:0] div_last(input logic [1:0] sel);
      case (sel)
         2'b00:   div_last = PRE_W'(3);
         2'b01:   div_last = PRE_W'(7);
         2'b10:   div_last = PRE_W'(31);
         default: div_last = PRE_W'(127);
      endcase
   endfunction

endpackage

// File: rtl/hpf_sync.sv
module hpf_sync #(
   parameter int unsigned WIDTH  = 3,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q_sync
);

   logic [WIDTH-1:0] stage_q [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (!rst_n) stage_q[s] <= '0;
               else        stage_q[s] <= d_async;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (!rst_n) stage_q[s] <= '0;
               else        stage_q[s] <= stage_q[s-1];
            end
         end
      end
   endgenerate

   assign q_sync = stage_q[STAGES-1];

endmodule

// File: rtl/hpf_tick_gen.sv
module hpf_tick_gen
   import hpf_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] clk_sel,
   output logic       tick
);

   logic [PRE_W-1:0] pre_q;
   logic [PRE_W-1:0] last;

   assign last = div_last(clk_sel);
   // >= so that a switch to a shorter period never overruns
   assign tick = (pre_q >= last);

   always_ff @(posedge clk) begin
      if (!rst_n)    pre_q <= '0;
      else if (tick) pre_q <= '0;
      else           pre_q <= pre_q + 1'b1;
   end

endmodule

// File: rtl/hpf_blank.sv
module hpf_blank #(
   parameter int unsigned DLY_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pwm_on,
   input  logic             tick,
   input  logic [DLY_W-1:0] blank_dly,
   output logic             blanking
);

   logic             pwm_q;
   logic [DLY_W-1:0] left_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pwm_q  <= 1'b0;
         left_q <= '0;
      end else begin
         pwm_q <= pwm_on;
         if (pwm_on && !pwm_q)            left_q <= blank_dly;
         else if (tick && left_q != '0)   left_q <= left_q - 1'b1;
      end
   end

   assign blanking = (left_q != '0);

endmodule

// File: rtl/hpf_debounce.sv
module hpf_debounce #(
   parameter int unsigned WIDTH = 3,
   parameter int unsigned CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             smp_en,
   input  logic [WIDTH-1:0] smp,
   input  logic [CNT_W-1:0] need,
   output logic [WIDTH-1:0] pos,
   output logic             chg
);

   localparam logic [CNT_W-1:0] RUN_MAX = '1;

   logic [WIDTH-1:0] cand_q;
   logic [CNT_W-1:0] run_q;
   logic [CNT_W-1:0] run_nxt;

   always_comb begin
      if (smp != cand_q)        run_nxt = CNT_W'(1);
      else if (run_q == RUN_MAX) run_nxt = RUN_MAX;
      else                      run_nxt = run_q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cand_q <= '0;
         run_q  <= '0;
         pos    <= '0;
         chg    <= 1'b0;
      end else begin
         chg <= 1'b0;
         if (smp_en) begin
            cand_q <= smp;
            run_q  <= run_nxt;
            if (run_nxt >= need && smp != pos) begin
               pos <= smp;
               chg <= 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/hall_pos_filter.sv
module hall_pos_filter
   import hpf_pkg::*;
#(
   parameter int unsigned HALL_W      = 3,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned CNT_W       = 4,
   parameter int unsigned DLY_W       = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [HALL_W-1:0] hall_in,
   input  logic              pwm_on,
   input  logic              lowside_on,
   input  logic              det_en,
   input  logic [1:0]        clk_sel,
   input  logic [1:0]        samp_mode,
   input  logic [CNT_W-1:0]  match_cnt,
   input  logic [DLY_W-1:0]  blank_dly,
   output logic [HALL_W-1:0] pos_out,
   output logic              pos_chg
);

   generate
      if (HALL_W < 1)      begin : g_bad_w    $error("HALL_W must be at least 1"); end
      if (SYNC_STAGES < 2) begin : g_bad_sync $error("SYNC_STAGES must be at least 2"); end
      if (CNT_W < 1)       begin : g_bad_cnt  $error("CNT_W must be at least 1"); end
      if (DLY_W < 1)       begin : g_bad_dly  $error("DLY_W must be at least 1"); end
   endgenerate

   logic [HALL_W-1:0] hall_s;
   logic              tick;
   logic              blanking;
   logic              gate;
   logic              smp_en;
   logic [CNT_W-1:0]  need;
   smp_mode_e         mode;

   hpf_sync #(.WIDTH(HALL_W), .STAGES(SYNC_STAGES)) i_sync (
      .clk(clk), .rst_n(rst_n), .d_async(hall_in), .q_sync(hall_s));

   hpf_tick_gen i_tick (
      .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .tick(tick));

   hpf_blank #(.DLY_W(DLY_W)) i_blank (
      .clk(clk), .rst_n(rst_n), .pwm_on(pwm_on), .tick(tick),
      .blank_dly(blank_dly), .blanking(blanking));

   assign mode = smp_mode_e'(samp_mode);

   always_comb begin
      case (mode)
         SMP_PWM:  gate = pwm_on;
         SMP_FREE: gate = 1'b1;
         SMP_LOW:  gate = lowside_on;
         default:  gate = 1'b0;
      endcase
   end

   assign smp_en = tick && gate && !blanking && det_en;
   assign need   = (match_cnt == '0) ? CNT_W'(1) : match_cnt;

   hpf_debounce #(.WIDTH(HALL_W), .CNT_W(CNT_W)) i_deb (
      .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .smp(hall_s),
      .need(need), .pos(pos_out), .chg(pos_chg));

endmodule

// File: rtl/hall_pos_filter_chk.sv
module hall_pos_filter_chk #(
   parameter int unsigned HALL_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              pwm_on,
   input logic              det_en,
   input logic [1:0]        samp_mode,
   input logic [HALL_W-1:0] pos_out,
   input logic              pos_chg
);

   // R8
   strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pos_chg |=> !pos_chg);

   // R8
   strobe_real_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pos_chg |-> (pos_out != $past(pos_out)));

   // R8
   no_silent_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pos_out != $past(pos_out)) |-> pos_chg);

   // R7
   disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !det_en |=> $stable(pos_out));

   // R5
   reserved_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (samp_mode == 2'b11) |=> $stable(pos_out));

   // R5
   pwm_gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (samp_mode == 2'b00 && !pwm_on) |=> $stable(pos_out));

endmodule

bind hall_pos_filter hall_pos_filter_chk #(.HALL_W(HALL_W)) i_chk (
   .clk(clk), .rst_n(rst_n), .pwm_on(pwm_on), .det_en(det_en),
   .samp_mode(samp_mode), .pos_out(pos_out), .pos_chg(pos_chg));

// File: tb/test_hall_pos_filter.sv
`timescale 1ns/1ps
module test_hall_pos_filter;

   typedef struct packed {
      logic [1:0]  mode;
      logic [1:0]  sel;
      logic [3:0]  cnt;
      logic [2:0]  hall;
      logic        pwm;
      logic        low;
      logic [15:0] hold;
      logic [2:0]  exp_pos;
      logic [1:0]  exp_chg;
   } vec_t;

   localparam int NV = 14;
   // mode, sel, cnt, hall, pwm, low, hold, expected pos, expected strobes
   localparam vec_t VECS [NV] = '{
      '{2'b01, 2'b00, 4'd3,  3'd3, 1'b0, 1'b0, 16'd40,  3'd3, 2'd1}, // R2 R3 basic
      '{2'b01, 2'b00, 4'd0,  3'd1, 1'b0, 1'b0, 16'd12,  3'd1, 2'd1}, // R3 count 0
      '{2'b01, 2'b00, 4'd1,  3'd5, 1'b0, 1'b0, 16'd12,  3'd5, 2'd1}, // R3 count 1
      '{2'b01, 2'b00, 4'd15, 3'd4, 1'b0, 1'b0, 16'd50,  3'd5, 2'd0}, // R3 15 not yet
      '{2'b01, 2'b00, 4'd15, 3'd4, 1'b0, 1'b0, 16'd40,  3'd4, 2'd1}, // R3 15 done
      '{2'b00, 2'b00, 4'd1,  3'd6, 1'b0, 1'b0, 16'd40,  3'd4, 2'd0}, // R5 pwm off
      '{2'b00, 2'b00, 4'd1,  3'd6, 1'b1, 1'b0, 16'd20,  3'd6, 2'd1}, // R5 pwm on
      '{2'b10, 2'b00, 4'd1,  3'd2, 1'b0, 1'b0, 16'd40,  3'd6, 2'd0}, // R5 low off
      '{2'b10, 2'b00, 4'd1,  3'd2, 1'b0, 1'b1, 16'd20,  3'd2, 2'd1}, // R5 low on
      '{2'b11, 2'b00, 4'd1,  3'd3, 1'b1, 1'b1, 16'd60,  3'd2, 2'd0}, // R5 reserved
      '{2'b01, 2'b11, 4'd2,  3'd3, 1'b0, 1'b0, 16'd100, 3'd2, 2'd0}, // R2 /128 early
      '{2'b01, 2'b11, 4'd2,  3'd3, 1'b0, 1'b0, 16'd200, 3'd3, 2'd1}, // R2 /128 done
      '{2'b01, 2'b10, 4'd10, 3'd1, 1'b0, 1'b0, 16'd250, 3'd3, 2'd0}, // R2 /32 early
      '{2'b01, 2'b10, 4'd10, 3'd1, 1'b0, 1'b0, 16'd150, 3'd1, 2'd1}  // R2 /32 done
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] hall_in = 3'd0;
   logic       pwm_on = 1'b0;
   logic       lowside_on = 1'b0;
   logic       det_en = 1'b1;
   logic [1:0] clk_sel = 2'b00;
   logic [1:0] samp_mode = 2'b01;
   logic [3:0] match_cnt = 4'd1;
   logic [6:0] blank_dly = 7'd0;
   logic [2:0] pos_out;
   logic       pos_chg;

   int tests = 0;
   int fails = 0;
   int strobes = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   hall_pos_filter i_hall_pos_filter (
      .clk(clk), .rst_n(rst_n), .hall_in(hall_in), .pwm_on(pwm_on),
      .lowside_on(lowside_on), .det_en(det_en), .clk_sel(clk_sel),
      .samp_mode(samp_mode), .match_cnt(match_cnt), .blank_dly(blank_dly),
      .pos_out(pos_out), .pos_chg(pos_chg));

   task automatic run(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (pos_chg) strobes++;
      end
   endtask

   task automatic check(input string req, input logic [2:0] exp_pos, input int exp_chg);
      tests++;
      if (pos_out !== exp_pos || strobes != exp_chg) begin
         fails++;
         $display("FAIL %s: pos=%0d strobes=%0d expected pos=%0d strobes=%0d",
                  req, pos_out, strobes, exp_pos, exp_chg);
      end
      strobes = 0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         tests++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      run(5);
      // R1 reset state
      check("R1 in reset", 3'd0, 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      tests++;
      if (pos_out !== 3'd0 || pos_chg !== 1'b0) begin
         fails++;
         $display("FAIL R1: pos=%0d chg=%0b expected pos=0 chg=0", pos_out, pos_chg);
      end
      strobes = 0;

      for (int v = 0; v < NV; v++) begin
         samp_mode  = VECS[v].mode;
         clk_sel    = VECS[v].sel;
         match_cnt  = VECS[v].cnt;
         hall_in    = VECS[v].hall;
         pwm_on     = VECS[v].pwm;
         lowside_on = VECS[v].low;
         run(int'(VECS[v].hold));
         check($sformatf("R2/R3/R5/R8 vector %0d", v), VECS[v].exp_pos, int'(VECS[v].exp_chg));
      end

      // R4 glitch rejection: pos is 1, need 5 samples on /4
      samp_mode = 2'b01; clk_sel = 2'b00; match_cnt = 4'd5;
      pwm_on = 1'b0; lowside_on = 1'b0;
      hall_in = 3'd6; run(12);
      hall_in = 3'd1; run(12);
      hall_in = 3'd6; run(12);
      hall_in = 3'd1; run(40);
      check("R4 glitch", 3'd1, 0);

      // R6 blanking: 100 ticks of 4 clocks after pwm rise
      match_cnt = 4'd1; blank_dly = 7'd100;
      run(10);
      pwm_on = 1'b1; hall_in = 3'd4;
      run(200);
      check("R6 blanked", 3'd1, 0);
      run(300);
      check("R6 released", 3'd4, 1);
      blank_dly = 7'd0;
      pwm_on = 1'b0;
      run(10);
      pwm_on = 1'b1; hall_in = 3'd5;
      run(20);
      check("R6 zero delay", 3'd5, 1);

      // R7 detection disabled
      det_en = 1'b0; hall_in = 3'd2;
      run(60);
      check("R7 disabled hold", 3'd5, 0);
      det_en = 1'b1;
      run(20);
      check("R7 re-enabled R8", 3'd2, 1);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule